// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

A behavioural, synthesizable model of a single-cycle-deselect synchronous burst SRAM. The array holds `2**ADDR_W` words, each made of `LANES` byte lanes of `LANE_W` bits. Addresses, write data, chip selects, strobes and write controls are sampled on the rising clock edge. The output enable and the sleep request act on the outputs without waiting for a clock.

A burst opens with one of two address strobes. The processor-side strobe is masked by the primary select and always starts a read. The controller-side strobe starts a read or a write, or it deselects the device. Cycles with no strobe continue the open burst. They either step a 2-bit counter over the low address bits or repeat the current address. Read data can leave straight from the array (flow-through) or through one more output register (pipeline). The data bus is modelled as a data word plus a drive flag, because no tristate pins exist.

A sleep request puts the device to sleep two clocks after it is seen. After wake-up there is a recovery window in which writes are refused and reported.

Top module: `sync_burst_sram`

## Requirements
- R1: The device is selected when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. The selects are sampled only on a strobe edge. `cpu_strobe_n`=0 with `sel_a_n`=1 is ignored, and the cycle acts as if no strobe were present.
- R2: `ctl_strobe_n`=0 while the device is not selected, or a processor strobe whose `sel_b`/`sel_c_n` deselect the device, closes the burst. The outputs are then not driven, and later strobe-free cycles do no access.
- R3: A burst started by `cpu_strobe_n` is a read whatever the write inputs are. A following strobe-free cycle with a write asserted and `burst_next_n`=1 writes to that same address.
- R4: `wr_all_n`=0 writes every lane. Otherwise `wr_byte_n`=0 writes each lane i whose `lane_wr_n[i]`=0, taking `wdata[i*LANE_W +: LANE_W]`. `wr_byte_n`=0 with no lane enabled, and both write controls high, give a read.
- R5: A read drives all lanes, whatever the lane enables are. A write cycle never drives the outputs.
- R6: With `pipe_mode`=0, data for a read sampled at edge k is valid (`rdata_oe`=1) between edge k and edge k+1. With `pipe_mode`=1 it is valid one clock later.
- R7: `out_en_n`=1 forces `rdata_oe`=0 at once. `out_en_n`=0 shows data only in a cycle that carries read data. `rdata` is 0 whenever `rdata_oe`=0.
- R8: Each strobe-free cycle with `burst_next_n`=0 advances a 2-bit count. The count wraps to the start word after four steps. With `burst_next_n`=1 the current address is repeated. The low address bits are start XOR count (INTERLEAVE=1, the default) or start plus count modulo 4 (INTERLEAVE=0).
- R9: If `sleep_req` is high at edges k and k+1, the device is asleep from edge k+1 on. While asleep it keeps the array, ignores all other inputs and drives nothing. It wakes one edge after the first edge that samples `sleep_req` low, once that low has also been held for the edge before.
- R10: For the RECOVER_CYC edges after wake-up, a write is dropped: no array change and no burst state change. `wr_err` is then 1 for the following clock. Deselects and reads proceed normally.
- R11: Reset closes the burst, clears sleep and recovery, and leaves `rdata_oe`=0 and `wr_err`=0. The array contents are left undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| cpu_strobe_n | input | 1 | Processor-side burst strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side burst strobe, active low |
| burst_next_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary select, active low |
| sel_b | input | 1 | Secondary select, active high |
| sel_c_n | input | 1 | Secondary select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write enable, active low |
| lane_wr_n | input | LANES | Lane selects, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| pipe_mode | input | 1 | 1 = pipeline output, 0 = flow-through |
| sleep_req | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Read data (0 when not driven) |
| rdata_oe | output | 1 | Data bus driven |
| wr_err | output | 1 | Write refused during recovery |

## Verification
The interesting overlap is the recovery window against an open burst. A continuing-burst write, with or without advance, falls into an edge on which recovery is still counting down. The write must then be dropped, the counter must not move, and the error flag must rise one clock later. The bench produces this by holding the controller writing through sleep entry, sleep and wake-up. A behavioural reference model then judges each edge, on the data bus, the drive flag and the error flag, and a final read-back shows that the refused writes left the array unchanged. A second overlap is a pipelined read still draining while the output enable toggles, which the bench checks against the model on every clock.

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int ADDR_W      = 6,
  parameter int LANES       = 4,
  parameter int LANE_W      = 9,
  parameter int RECOVER_CYC = 3,
  parameter int INTERLEAVE  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    burst_next_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    pipe_mode,
  input  logic                    sleep_req,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe,
  output logic                    wr_err
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HW    = ADDR_W - 2;
  localparam int RW    = $clog2(RECOVER_CYC + 1);

  logic [DW-1:0]     mem [DEPTH];
  logic              active, ft_v, pipe_v, s1, s2;
  logic [HW-1:0]     hi_q;
  logic [1:0]        base_q, cnt_q;
  logic [ADDR_W-1:0] acc_q;
  logic [DW-1:0]     pipe_d;
  logic [RW-1:0]     rec_cnt;

  function automatic logic [1:0] order(input logic [1:0] b, input logic [1:0] c);
    return (INTERLEAVE != 0) ? (b ^ c) : (b + c);
  endfunction

  wire cpu_go   = !cpu_strobe_n && !sel_a_n;
  wire ctl_go   = !ctl_strobe_n && !cpu_go;
  wire selected = !sel_a_n && sel_b && !sel_c_n;
  wire start    = (cpu_go || ctl_go) && selected;
  wire desel    = (cpu_go || ctl_go) && !selected;
  wire cont     = !cpu_go && !ctl_go && active;
  wire awake    = !s2;

  wire [LANES-1:0] wr_mask = !wr_all_n ? {LANES{1'b1}} :
                             (!wr_byte_n ? ~lane_wr_n : {LANES{1'b0}});
  wire is_wr   = (|wr_mask) && !cpu_go;
  wire access  = start || cont;
  wire blocked = (rec_cnt != '0) && is_wr && access;

  wire [1:0] cnt_nx = (cont && !burst_next_n) ? cnt_q + 2'd1 : cnt_q;
  wire [ADDR_W-1:0] eff_addr = start ? addr : {hi_q, order(base_q, cnt_nx)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ft_v    <= 1'b0;
      pipe_v  <= 1'b0;
      pipe_d  <= '0;
      s1      <= 1'b0;
      s2      <= 1'b0;
      rec_cnt <= '0;
      wr_err  <= 1'b0;
      hi_q    <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      s1     <= sleep_req;
      s2     <= s1;
      pipe_v <= ft_v;
      pipe_d <= mem[acc_q];
      wr_err <= awake && blocked;
      if (s2 && !s1)
        rec_cnt <= RW'(RECOVER_CYC);
      else if (rec_cnt != '0 && awake)
        rec_cnt <= rec_cnt - 1'b1;
      if (!awake || blocked) begin
        ft_v <= 1'b0;
      end else begin
        if (desel) active <= 1'b0;
        if (start) begin
          active <= 1'b1;
          hi_q   <= addr[ADDR_W-1:2];
          base_q <= addr[1:0];
          cnt_q  <= 2'd0;
        end else if (cont) begin
          cnt_q <= cnt_nx;
        end
        ft_v  <= access && !is_wr;
        acc_q <= eff_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (awake && !blocked && access && is_wr)
      for (int i = 0; i < LANES; i++)
        if (wr_mask[i]) mem[eff_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  wire          drive = pipe_mode ? pipe_v : ft_v;
  wire [DW-1:0] rd    = pipe_mode ? pipe_d : mem[acc_q];
  assign rdata_oe = drive && !out_en_n && awake;
  assign rdata    = rdata_oe ? rd : '0;

  AST_STRAY_CPU_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && sel_a_n && ctl_strobe_n && !active && awake) |=> !ft_v); // R1
  AST_DESEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (desel && awake) |=> (!active && !ft_v)); // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (access && is_wr && awake) |=> !ft_v); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !burst_next_n && awake && !blocked) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R8
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && burst_next_n && awake) |=> $stable(cnt_q)); // R8
  AST_RECOVERY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((rec_cnt != '0) && access && is_wr && awake) |=> wr_err); // R10
endmodule

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int REC = 3;
  logic clk = 0, rst_n = 0;
  logic [5:0] addr = 0;
  logic [35:0] wdata = 0;
  logic cpu_n = 1, ctl_n = 1, adv_n = 1, sa_n = 0, sb = 1, sc_n = 0;
  logic gw_n = 1, bw_n = 1, oe_n = 0, pmode = 0, slp = 0;
  logic [3:0] ln_n = 4'hF;
  logic [35:0] rdata;
  logic rdata_oe, wr_err;
  int total = 0, fails = 0;
  bit done = 0;
  string cur_req = "R11";

  always #10 clk = ~clk;

  sync_burst_sram #(.RECOVER_CYC(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .cpu_strobe_n(cpu_n), .ctl_strobe_n(ctl_n), .burst_next_n(adv_n),
    .sel_a_n(sa_n), .sel_b(sb), .sel_c_n(sc_n), .wr_all_n(gw_n), .wr_byte_n(bw_n),
    .lane_wr_n(ln_n), .out_en_n(oe_n), .pipe_mode(pmode), .sleep_req(slp),
    .rdata(rdata), .rdata_oe(rdata_oe), .wr_err(wr_err));

  // behavioural reference
  logic [35:0] mem_m [0:63];
  bit m_act, m_ftv, m_pv, m_err, h1, h2;
  logic [35:0] m_ftd, m_pd;
  int m_hi, m_base, m_cnt, m_rec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_ftv = 0; m_pv = 0; m_err = 0; h1 = 0; h2 = 0; m_rec = 0;
    end else begin
      m_pv = m_ftv; m_pd = m_ftd;
      if (h2) begin
        m_ftv = 0; m_err = 0;
      end else begin
        int kind, tgt; bit w, sel, wr, blk;
        sel = !sa_n && sb && !sc_n;
        wr = !gw_n || (!bw_n && ln_n != 4'hF);
        tgt = 0;
        if (!cpu_n && !sa_n) begin kind = sel ? 1 : 2; w = 0; end
        else if (!ctl_n) begin kind = sel ? 1 : 2; w = wr; end
        else if (m_act) begin kind = 3; w = wr; end
        else begin kind = 0; w = 0; end
        blk = m_rec > 0 && w && (kind == 1 || kind == 3);
        m_err = blk; m_ftv = 0;
        if (!blk) begin
          if (kind == 1) begin m_act = 1; m_hi = addr / 4; m_base = addr % 4; m_cnt = 0; tgt = addr; end
          if (kind == 2) m_act = 0;
          if (kind == 3) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            tgt = m_hi * 4 + (m_base ^ m_cnt);
          end
          if (kind == 1 || kind == 3) begin
            if (w) begin
              for (int i = 0; i < 4; i++)
                if (!gw_n || (!bw_n && !ln_n[i])) mem_m[tgt][i*9 +: 9] = wdata[i*9 +: 9];
            end else begin
              m_ftv = 1; m_ftd = mem_m[tgt];
            end
          end
        end
      end
      if (h2 && !h1) m_rec = REC;
      else if (m_rec > 0 && !h2) m_rec = m_rec - 1;
      h2 = h1; h1 = slp;
    end
  end

  task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit e_oe; logic [35:0] e_d;
    e_oe = (pmode ? m_pv : m_ftv) && !oe_n && !h2;
    e_d = e_oe ? (pmode ? m_pd : m_ftd) : 36'h0;
    check(cur_req, {rdata_oe, rdata}, {e_oe, e_d});
    check("R10", {36'h0, wr_err}, {36'h0, m_err});
  endtask

  task automatic tick();
    @(posedge clk); #5; compare(); #5;
  endtask

  task automatic clr();
    cpu_n = 1; ctl_n = 1; adv_n = 1; sa_n = 0; sb = 1; sc_n = 0;
    gw_n = 1; bw_n = 1; ln_n = 4'hF; wdata = 0;
  endtask

  task automatic ctl_op(input int a, input logic g, input logic b, input logic [3:0] l, input logic [35:0] d);
    clr(); ctl_n = 0; addr = 6'(a); gw_n = g; bw_n = b; ln_n = l; wdata = d; tick();
  endtask

  task automatic cpu_op(input int a, input logic g);
    clr(); cpu_n = 0; addr = 6'(a); gw_n = g; tick();
  endtask

  task automatic nxt(input logic av, input logic g, input logic b, input logic [3:0] l, input logic [35:0] d);
    clr(); adv_n = av; gw_n = g; bw_n = b; ln_n = l; wdata = d; tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin clr(); tick(); end
  endtask

  function automatic logic [35:0] pat(input int a, input int s);
    return 36'(a * 36'h1_0203_0405) ^ 36'(s * 36'h7_1F3C_5A9D);
  endfunction

  initial begin
    clr();
    #35;
    check("R11", {35'h0, rdata_oe, wr_err}, 37'h0);
    rst_n = 1;
    #5;
    cur_req = "R11"; idle(2);
    cur_req = "R4";
    for (int a = 0; a < 32; a++) ctl_op(a, 0, 1, 4'hF, pat(a, 1));
    cur_req = "R6"; pmode = 0;
    for (int a = 0; a < 6; a++) ctl_op(a, 1, 1, 4'hF, 0);
    idle(1);
    pmode = 1;
    for (int a = 6; a < 12; a++) ctl_op(a, 1, 1, 4'hF, 0);
    idle(2);
    cur_req = "R4"; pmode = 0;
    ctl_op(3, 1, 0, 4'b1010, pat(3, 9));
    ctl_op(4, 0, 0, 4'b0000, pat(4, 9));
    ctl_op(5, 1, 0, 4'hF, pat(5, 9));
    cur_req = "R5";
    ctl_op(3, 1, 1, 4'b0000, 0);
    ctl_op(4, 1, 1, 4'hF, 0);
    ctl_op(5, 1, 1, 4'hF, 0);
    cur_req = "R3";
    cpu_op(8, 0);
    nxt(1, 1, 0, 4'b1100, pat(8, 5));
    nxt(1, 1, 1, 4'hF, 0);
    ctl_op(8, 1, 1, 4'hF, 0);
    cur_req = "R1";
    clr(); cpu_n = 0; sa_n = 1; addr = 6'd9; tick();
    nxt(0, 1, 1, 4'hF, 0);
    clr(); sb = 0; sc_n = 1; tick();
    cur_req = "R2";
    clr(); ctl_n = 0; sb = 0; addr = 6'd2; tick();
    nxt(0, 1, 1, 4'hF, 0);
    clr(); cpu_n = 0; sa_n = 1; addr = 6'd2; tick();
    clr(); cpu_n = 0; sc_n = 1; addr = 6'd2; tick();
    idle(2);
    cur_req = "R8";
    for (int m = 0; m < 2; m++) begin
      pmode = logic'(m);
      ctl_op(14, 1, 1, 4'hF, 0);
      for (int k = 0; k < 5; k++) nxt(0, 1, 1, 4'hF, 0);
      nxt(1, 1, 1, 4'hF, 0);
      nxt(0, 1, 1, 4'hF, 0);
      idle(2);
    end
    pmode = 0;
    ctl_op(17, 0, 1, 4'hF, pat(17, 3));
    for (int k = 0; k < 3; k++) nxt(0, 0, 1, 4'hF, pat(18 + k, 3));
    nxt(1, 1, 0, 4'b0111, pat(40, 3));
    cpu_op(16, 1);
    for (int k = 0; k < 4; k++) nxt(0, 1, 1, 4'hF, 0);
    cur_req = "R7";
    for (int m = 0; m < 2; m++) begin
      pmode = logic'(m);
      ctl_op(20, 1, 1, 4'hF, 0);
      oe_n = 1; nxt(0, 1, 1, 4'hF, 0);
      oe_n = 0; nxt(0, 1, 1, 4'hF, 0);
      oe_n = 1; nxt(0, 1, 1, 4'hF, 0);
      oe_n = 0; nxt(1, 0, 1, 4'hF, pat(22, 7));
      nxt(1, 1, 1, 4'hF, 0);
      idle(2);
    end
    cur_req = "R9"; pmode = 0;
    ctl_op(24, 1, 1, 4'hF, 0);
    slp = 1;
    for (int k = 0; k < 6; k++) ctl_op(25 + (k % 2), 0, 1, 4'hF, pat(25, 20 + k));
    slp = 0;
    for (int k = 0; k < 3; k++) ctl_op(26, 0, 1, 4'hF, pat(26, 40 + k));
    cur_req = "R10";
    ctl_op(28, 1, 1, 4'hF, 0);
    nxt(0, 0, 1, 4'hF, pat(29, 50));
    nxt(1, 1, 0, 4'b1110, pat(29, 51));
    for (int k = 0; k < 3; k++) nxt(0, 0, 1, 4'hF, pat(30, 52 + k));
    ctl_op(24, 1, 1, 4'hF, 0);
    for (int a = 25; a < 32; a++) ctl_op(a, 1, 1, 4'hF, 0);
    pmode = 1;
    slp = 1; idle(4); slp = 0;
    cpu_op(25, 1);
    ctl_op(27, 0, 1, 4'hF, pat(27, 60));
    ctl_op(27, 1, 1, 4'hF, 0);
    idle(4);
    ctl_op(27, 0, 1, 4'hF, pat(27, 61));
    ctl_op(27, 1, 1, 4'hF, 0);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule